// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block keeps the frame clock of a full-speed USB host controller. Software programs four values through a register port that only takes whole 32-bit words. These values are the frame length in bit times, the full-speed packet-size budget, the point in the frame where periodic work may begin, and the low-speed commit threshold. A bit-time tick from elsewhere in the controller drives a 14-bit down counter that shows how much of the current frame is left. When the counter has run out, the next tick starts a new frame. The counter reloads, the 16-bit frame number steps forward, and a start-of-frame strobe fires for one cycle.

Two qualifiers come from the counter for the transaction scheduler. The periodic-window flag rises once the time left drops to the periodic start value or below it, and it stays up until the frame ends. The low-speed commit flag shows whether there is still room to start a short low-speed packet before the end of the frame. The packet-size budget is only held in a register and driven out, for use by the scheduler.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the frame number is 0. The frame length register and the remaining counter both hold 11999. The start-of-frame strobe is low.
- R2: The remaining counter drops by one on each clock that has `bitTick` high while it is non-zero. Without a tick, neither the counter nor the frame number changes.
- R3: A tick that arrives with the remaining count at zero reloads the counter from the frame length register and adds one to the frame number. In the following cycle `sofPulse` is high for exactly one cycle, together with the new frame number. No other cycle has `sofPulse` high.
- R4: The frame number goes from 0xFFFF to 0 at the next frame start.
- R5: A new frame length written through the register port does not change the running count. It is used first at the next reload.
- R6: `periodicGo` is high whenever the remaining count is less than or equal to the periodic start value. Once high, it stays high until the next frame start, even if the start value is changed afterwards.
- R7: `lsCommitOk` is high exactly when the remaining count is strictly greater than the low-speed threshold.
- R8: Reads are combinational on word address `regAddr`. Address 0 returns the frame length in bits 13:0 and the packet budget in bits 30:16. Address 1 returns the remaining count in bits 13:0. Address 2 returns the frame number in bits 15:0. Address 3 returns the periodic start value in bits 13:0. Address 4 returns the low-speed threshold in bits 10:0. All other bits and all other addresses read 0.
- R9: A write to address 1, address 2 or an unmapped address changes nothing.
- R10: `fsMaxPacket` drives the 15-bit packet budget written at address 0, bits 30:16. It resets to 10104.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per USB bit time |
| regWrEn | input | 1 | Word write strobe |
| regAddr | input | 3 | Word address for reads and writes |
| regWrData | input | 32 | Write data word |
| regRdData | output | 32 | Read data word for `regAddr` |
| remaining | output | 14 | Bit times left in the current frame |
| frameNum | output | 16 | Current frame number |
| sofPulse | output | 1 | One-cycle start-of-frame strobe |
| periodicGo | output | 1 | Periodic processing may start |
| lsCommitOk | output | 1 | A low-speed packet may still be committed |
| fsMaxPacket | output | 15 | Full-speed packet-size budget |

## Verification
A wrong remaining count shows up on `remaining` and on the read port in the next cycle. It then spreads to both qualifier flags. When the frame boundary comes, it shifts the strobe and the frame-number step by at least one tick. A stale frame length register gives a wrong reload value, which is only visible after the current frame has run out. For this reason the bench writes a new length mid-frame and then runs across the boundary. A sticky flag that failed to clear would only appear after the boundary, in a frame whose count is still above the start value. The bench compares every output against a behavioural model on every clock, so each of these faults is caught in the first cycle in which it reaches a port.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
  // word addresses of the register port
  localparam int unsigned ADDR_CFG    = 0;
  localparam int unsigned ADDR_REMAIN = 1;
  localparam int unsigned ADDR_FNUM   = 2;
  localparam int unsigned ADDR_PSTART = 3;
  localparam int unsigned ADDR_LSTH   = 4;

  // position of the packet budget inside the configuration word
  localparam int unsigned CFG_PKT_LSB = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic decrement;
    logic wrCfg;
    logic wrPstart;
    logic wrLsTh;
  } ftStrobes_t;
endpackage

// File: rtl/usb_ft_ctrl.sv
module usb_ft_ctrl
  import usb_ft_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              remZero,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ftStrobes_t        stb,
  output logic              sofPulse
);
  logic sofQ;

  always_comb begin
    stb           = '0;
    stb.reload    = bitTick & remZero;
    stb.decrement = bitTick & ~remZero;
    stb.wrCfg     = regWrEn & (regAddr == ADDR_W'(ADDR_CFG));
    stb.wrPstart  = regWrEn & (regAddr == ADDR_W'(ADDR_PSTART));
    stb.wrLsTh    = regWrEn & (regAddr == ADDR_W'(ADDR_LSTH));
  end

  // strobe is registered so it lines up with the new frame number
  always_ff @(posedge clk) begin
    if (!rstN) sofQ <= 1'b0;
    else       sofQ <= stb.reload;
  end

  assign sofPulse = sofQ;
endmodule

// File: rtl/usb_ft_datapath.sv
module usb_ft_datapath
  import usb_ft_pkg::*;
#(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned IVL_W        = 14,
  parameter int unsigned PKT_W        = 15,
  parameter int unsigned FNUM_W       = 16,
  parameter int unsigned LS_W         = 11,
  parameter int unsigned DEF_INTERVAL = 11999,
  parameter int unsigned DEF_PKT      = 10104,
  parameter int unsigned DEF_PSTART   = 10799,
  parameter int unsigned DEF_LSTH     = 1576
) (
  input  logic              clk,
  input  logic              rstN,
  input  ftStrobes_t        stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [IVL_W-1:0]  remaining,
  output logic [FNUM_W-1:0] frameNum,
  output logic              remZero,
  output logic              periodicGo,
  output logic              lsCommitOk,
  output logic [PKT_W-1:0]  fsMaxPacket,
  output logic [IVL_W-1:0]  intervalQ,
  output logic [IVL_W-1:0]  pstartQ,
  output logic [LS_W-1:0]   lsThQ
);
  logic [IVL_W-1:0]  remQ;
  logic [FNUM_W-1:0] fnQ;
  logic [PKT_W-1:0]  pktQ;
  logic              stickyQ;
  logic              pastStart;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData;

  // frame counter and frame number
  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ <= IVL_W'(DEF_INTERVAL);
      fnQ  <= '0;
    end else if (stb.reload) begin
      remQ <= intervalQ;
      fnQ  <= fnQ + 1'b1;
    end else if (stb.decrement) begin
      remQ <= remQ - 1'b1;
    end
  end

  // programmable values; the length is only read at reload
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalQ <= IVL_W'(DEF_INTERVAL);
      pktQ      <= PKT_W'(DEF_PKT);
      pstartQ   <= IVL_W'(DEF_PSTART);
      lsThQ     <= LS_W'(DEF_LSTH);
    end else begin
      if (stb.wrCfg) begin
        intervalQ <= regWrData[IVL_W-1:0];
        pktQ      <= regWrData[CFG_PKT_LSB +: PKT_W];
      end
      if (stb.wrPstart) pstartQ <= regWrData[IVL_W-1:0];
      if (stb.wrLsTh)   lsThQ   <= regWrData[LS_W-1:0];
    end
  end

  // periodic window: held until the frame ends
  assign pastStart = (remQ <= pstartQ);

  always_ff @(posedge clk) begin
    if (!rstN)           stickyQ <= 1'b0;
    else if (stb.reload) stickyQ <= 1'b0;
    else if (pastStart)  stickyQ <= 1'b1;
  end

  assign periodicGo  = stickyQ | pastStart;
  assign lsCommitOk  = (remQ > IVL_W'(lsThQ));
  assign remZero     = (remQ == '0);
  assign remaining   = remQ;
  assign frameNum    = fnQ;
  assign fsMaxPacket = pktQ;

  // readback
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CFG): begin
        regRdData[IVL_W-1:0]             = intervalQ;
        regRdData[CFG_PKT_LSB +: PKT_W]  = pktQ;
      end
      ADDR_W'(ADDR_REMAIN): regRdData[IVL_W-1:0]  = remQ;
      ADDR_W'(ADDR_FNUM):   regRdData[FNUM_W-1:0] = fnQ;
      ADDR_W'(ADDR_PSTART): regRdData[IVL_W-1:0]  = pstartQ;
      ADDR_W'(ADDR_LSTH):   regRdData[LS_W-1:0]   = lsThQ;
      default:              regRdData = '0;
    endcase
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_ft_pkg::*;
#(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned IVL_W        = 14,
  parameter int unsigned PKT_W        = 15,
  parameter int unsigned FNUM_W       = 16,
  parameter int unsigned LS_W         = 11,
  parameter int unsigned DEF_INTERVAL = 11999,
  parameter int unsigned DEF_PKT      = 10104,
  parameter int unsigned DEF_PSTART   = 10799,
  parameter int unsigned DEF_LSTH     = 1576
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [IVL_W-1:0]  remaining,
  output logic [FNUM_W-1:0] frameNum,
  output logic              sofPulse,
  output logic              periodicGo,
  output logic              lsCommitOk,
  output logic [PKT_W-1:0]  fsMaxPacket
);
  ftStrobes_t       stb;
  logic             remZero;
  logic [IVL_W-1:0] intervalQ;
  logic [IVL_W-1:0] pstartQ;
  logic [LS_W-1:0]  lsThQ;

  usb_ft_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .remZero(remZero),
    .regWrEn(regWrEn), .regAddr(regAddr), .stb(stb), .sofPulse(sofPulse)
  );

  usb_ft_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IVL_W(IVL_W), .PKT_W(PKT_W),
    .FNUM_W(FNUM_W), .LS_W(LS_W), .DEF_INTERVAL(DEF_INTERVAL),
    .DEF_PKT(DEF_PKT), .DEF_PSTART(DEF_PSTART), .DEF_LSTH(DEF_LSTH)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .remaining(remaining),
    .frameNum(frameNum), .remZero(remZero), .periodicGo(periodicGo),
    .lsCommitOk(lsCommitOk), .fsMaxPacket(fsMaxPacket),
    .intervalQ(intervalQ), .pstartQ(pstartQ), .lsThQ(lsThQ)
  );
endmodule

// File: rtl/usb_ft_checker.sv
module usb_ft_checker #(
  parameter int unsigned IVL_W  = 14,
  parameter int unsigned FNUM_W = 16,
  parameter int unsigned LS_W   = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitTick,
  input logic [IVL_W-1:0]  remaining,
  input logic [FNUM_W-1:0] frameNum,
  input logic              sofPulse,
  input logic              periodicGo,
  input logic              lsCommitOk,
  input logic [IVL_W-1:0]  pstartQ,
  input logic [LS_W-1:0]   lsThQ
);
  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> ($stable(remaining) && $stable(frameNum)));

  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && remaining != '0) |=> (remaining == $past(remaining) - 1'b1));

  // R3
  sof_on_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && remaining == '0) |=> sofPulse);

  // R3
  no_stray_sof_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bitTick && remaining == '0) |=> !sofPulse);

  // R4
  fnum_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> (frameNum == FNUM_W'($past(frameNum) + 1'b1)));

  // R6
  periodic_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remaining <= pstartQ) |-> periodicGo);

  // R7
  ls_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lsCommitOk == (remaining > IVL_W'(lsThQ)));
endmodule

bind usb_frame_timer usb_ft_checker #(
  .IVL_W(IVL_W), .FNUM_W(FNUM_W), .LS_W(LS_W)
) i_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .remaining(remaining),
  .frameNum(frameNum), .sofPulse(sofPulse), .periodicGo(periodicGo),
  .lsCommitOk(lsCommitOk), .pstartQ(pstartQ), .lsThQ(lsThQ)
);

// File: tb/test_usb_frame_timer.sv
`timescale 1ns/1ps
module test_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [13:0] remaining;
  logic [15:0] frameNum;
  logic        sofPulse, periodicGo, lsCommitOk;
  logic [14:0] fsMaxPacket;

  always #2 clk = ~clk;

  usb_frame_timer i_usb_frame_timer (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .remaining(remaining), .frameNum(frameNum), .sofPulse(sofPulse),
    .periodicGo(periodicGo), .lsCommitOk(lsCommitOk), .fsMaxPacket(fsMaxPacket)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  int mRem, mFn, mInt, mPkt, mPs, mLs;
  bit mSticky, mSof;
  bit wrapSeen = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint mRead(input int a);
    case (a)
      0: return longint'(mInt) | (longint'(mPkt) << 16);
      1: return mRem;
      2: return mFn;
      3: return mPs;
      4: return mLs;
      default: return 0;
    endcase
  endfunction

  task automatic compareAll();
    check("R2", "remaining", remaining, mRem);
    check("R3", "frameNum", frameNum, mFn);
    check("R3", "sofPulse", sofPulse, mSof);
    check("R6", "periodicGo", periodicGo, (mSticky || mRem <= mPs) ? 1 : 0);
    check("R7", "lsCommitOk", lsCommitOk, (mRem > mLs) ? 1 : 0);
    check("R10", "fsMaxPacket", fsMaxPacket, mPkt);
    check("R8", "regRdData", regRdData, mRead(int'(regAddr)));
  endtask

  task automatic step(input bit tk, input bit we, input int a, input logic [31:0] d);
    int prevFn;
    bit expiry;
    bitTick = tk; regWrEn = we; regAddr = 3'(a); regWrData = d;
    prevFn = mFn;
    expiry = tk && (mRem == 0);
    // periodic window uses the values in front of the edge
    if (expiry) mSticky = 0;
    else if (mRem <= mPs) mSticky = 1;
    if (expiry) begin
      mRem = mInt;
      mFn = (mFn + 1) % 65536;
    end else if (tk) begin
      mRem = mRem - 1;
    end
    mSof = expiry;
    if (we) begin
      case (a)
        0: begin mInt = int'(d[13:0]); mPkt = int'(d[30:16]); end
        3: mPs = int'(d[13:0]);
        4: mLs = int'(d[10:0]);
        default: ;
      endcase
    end
    @(negedge clk);
    compareAll();
    if (prevFn == 65535 && frameNum == 16'd0) wrapSeen = 1;
  endtask

  task automatic run(input int n, input int tickMod);
    for (int i = 0; i < n; i++)
      step((tickMod == 0) ? 1'b0 : ((i % tickMod) != 0 || tickMod == 1), 1'b0, i % 8, '0);
  endtask

  initial begin
    mRem = 11999; mFn = 0; mInt = 11999; mPkt = 10104; mPs = 10799; mLs = 1576;
    mSticky = 0; mSof = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "frameNum", frameNum, 0);
    check("R1", "remaining", remaining, 11999);
    check("R1", "sofPulse", sofPulse, 0);
    check("R1", "interval readback", regRdData[13:0], 11999);
    check("R10", "reset budget", fsMaxPacket, 10104);

    // R2: no tick, nothing moves
    run(40, 0);
    run(100, 1);
    // R5, R10: new length and budget mid-frame
    step(1, 1, 0, {1'b0, 15'h1234, 2'b00, 14'd30});
    check("R5", "count after length write", remaining, 11999 - 101);
    step(1, 1, 3, 32'd5000);
    step(1, 1, 4, 32'd200);
    // R3, R6, R7: cross the boundary with gapped ticks
    run(15200, 5);
    check("R5", "new frame length in use", frameNum >= 16'd2, 1);
    // R9: read-only and unmapped writes
    step(0, 1, 1, 32'hFFFF_FFFF);
    step(0, 1, 2, 32'hFFFF_FFFF);
    step(0, 1, 5, 32'hFFFF_FFFF);
    step(0, 1, 7, 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) step(0, 0, a, '0);
    // R6: lower the start value once the window is open
    step(1, 1, 3, 32'd20);
    run(15, 1);
    step(1, 1, 3, 32'd2);
    run(60, 2);
    // R7: threshold sweep
    step(1, 1, 4, 32'd10);
    run(80, 3);
    step(1, 1, 4, 32'd40);
    run(40, 1);
    // R4: one-tick frames to reach the wrap
    step(1, 1, 0, {1'b0, 15'h0040, 2'b00, 14'd0});
    run(65600, 1);
    check("R4", "wrap seen", wrapSeen, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule